// File: doc/BRIEF.md
# I/O Port Address Decoder

This block sits on a processor bus that keeps I/O space apart from memory space. It watches the I/O address, the bus-ownership flag and the two active-low I/O strobes. From these it produces eight active-low block selects and serves two ports. A read port puts external pin data on the read-data lines, and an output port register captures the write data. The bus is modelled as a read-data vector with an output-enable flag, not as a three-state net. When the enable is low, the read-data lines are held at zero.

A block of eight device slots is recognised when the address bits above the select field match a base value. The three bits in the middle of the address pick the slot. The lowest five bits belong to the device inside a slot. A parameter sets the decoding mode. Absolute decoding checks every address line, including the device offset of each port. Linear decoding checks only the two lines just above the select field and ignores the device offset. Linear decoding is cheaper, and it lets one port answer at many aliased addresses.

A flag marks each access as a short (8-bit) port address or a full 16-bit one. On a short access, only lines 7:0 are used.

Top module: `io_port_decoder`

## Requirements
- R1: While `aen` is high, every bit of `sel_n` is 1 and `rd_oe` is 0, whatever the address and strobes are.
- R2: While `aen` is low and the high address lines match `BASE_HI`, exactly one bit of `sel_n` is low. Its index is `addr[7:5]`, and the selects do not depend on the strobes.
- R3: In absolute mode with a full-width access, any 1 in `addr[15:8]` (with `BASE_HI` = 0) leaves all selects high.
- R4: With `addr_wide` = 0, lines 15:8 are ignored, so the decode depends only on `addr[7:0]`.
- R5: In linear mode, only `addr[9:8]` are compared above the select field and the device offset is ignored. As a result, 0x1064, 0x0064 and 0x007F all reach slot 3, and 0x0082 reaches the output port at slot 4.
- R6: `rd_oe` is 1 exactly when the read port is hit and `ior_n` is 0. While `rd_oe` is 1, `rd_data` equals `port_in`; otherwise `rd_data` is zero.
- R7: In absolute mode, the read port needs slot `IN_SLOT` (3) with `addr[4:0]` = `IN_OFS` (4). Offset 5 in the same slot gives no `rd_oe`.
- R8: The output port is at slot `OUT_SLOT` (4) with offset `OUT_OFS` (1), so its absolute address is 0x081. The address and data present in the last clock with `iow_n` low are the ones used. `port_out` takes that data in the clock after the one in which `iow_n` is first seen high again.
- R9: A write strobe to another address, or one given while `aen` is high, leaves `port_out` unchanged.
- R10: While `rst_n` is low, `port_out` is zero.
- R11: The read strobe never changes `port_out`, and a write strobe never raises `rd_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output port register |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | High while another master owns the bus |
| addr | input | ADDR_W (16) | I/O port address |
| addr_wide | input | 1 | 1 = 16-bit port address, 0 = 8-bit port address |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| wr_data | input | DATA_W (8) | Write data from the bus |
| rd_data | output | DATA_W (8) | Read data toward the bus, zero when not driven |
| rd_oe | output | 1 | Read port is driving the bus |
| sel_n | output | 8 | Active-low block selects, one per slot |
| port_in | input | DATA_W (8) | External pins of the read port |
| port_out | output | DATA_W (8) | Output port register |

## Verification
The bench builds two instances that share every input. Both use base 0, read port 3/4 and output port 4/1. One instance uses absolute decoding and the other uses linear decoding, so every stimulus also shows the difference between the two modes. High-line addresses such as 0x1064 and 0x1081, and off-offset addresses such as 0x065 and 0x082, therefore check rejection and aliasing in the same cycle. Short accesses with junk in the upper byte check that those lines are ignored in both modes.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

  typedef enum logic {
    DEC_ABSOLUTE = 1'b0,
    DEC_LINEAR   = 1'b1
  } dec_mode_e;

  // mask of the n lowest bits, n limited to 0..32
  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // equality of a and b over the lines marked in m
  function automatic logic masked_eq(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input logic [31:0] m);
    return ((a ^ b) & m) == 32'd0;
  endfunction

  // device offset check inside a slot; linear decoding skips it
  function automatic logic offset_ok(input logic [7:0] dev,
                                     input logic [7:0] ofs,
                                     input dec_mode_e mode);
    return (mode == DEC_LINEAR) || (dev == ofs);
  endfunction

endpackage

// File: rtl/io_blk_enable.sv
module io_blk_enable
  import iodec_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          LOW_W    = 8,
  parameter int          NARROW_W = 8,
  parameter int          LIN_W    = 2,
  parameter int unsigned BASE_HI  = 0,
  parameter dec_mode_e   MODE     = DEC_ABSOLUTE
) (
  input  logic              aen,
  input  logic              addr_wide,
  input  logic [ADDR_W-1:0] addr,
  output logic              blk_en
);
  localparam int HI_W = ADDR_W - LOW_W;
  localparam int CMP_W = (MODE == DEC_LINEAR) ? LIN_W : HI_W;

  logic [HI_W-1:0] hi_raw;
  logic [HI_W-1:0] narrow_keep;
  logic [HI_W-1:0] hi_eff;
  logic [31:0]     cmp_mask;

  assign hi_raw = addr[ADDR_W-1:LOW_W];

  // lines of the high field that still exist on a short port address
  genvar j;
  generate
    for (j = 0; j < HI_W; j++) begin : g_narrow
      assign narrow_keep[j] = (LOW_W + j) < NARROW_W;
    end
  endgenerate

  assign hi_eff   = addr_wide ? hi_raw : (hi_raw & narrow_keep);
  assign cmp_mask = low_ones(CMP_W);
  assign blk_en   = !aen && masked_eq(32'(hi_eff), 32'(BASE_HI), cmp_mask);
endmodule

// File: rtl/io_sel_dec.sv
module io_sel_dec #(
  parameter int SEL_W = 3,
  localparam int NSEL = 1 << SEL_W
) (
  input  logic             blk_en,
  input  logic [SEL_W-1:0] slot,
  output logic [NSEL-1:0]  sel_n
);
  genvar k;
  generate
    for (k = 0; k < NSEL; k++) begin : g_sel
      assign sel_n[k] = !(blk_en && (slot == SEL_W'(k)));
    end
  endgenerate
endmodule

// File: rtl/io_out_port.sv
module io_out_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              iow_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] port_q,
  output logic [DATA_W-1:0] hold_q,
  output logic              commit
);
  logic iow_q;
  logic armed_q;

  // the strobe is released: this cycle sees iow_n high, the previous one saw it low
  assign commit = iow_n && !iow_q && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q   <= 1'b1;
      armed_q <= 1'b0;
      hold_q  <= '0;
      port_q  <= '0;
    end else begin
      iow_q <= iow_n;
      if (!iow_n) begin
        armed_q <= hit;
        if (hit) hold_q <= wr_data;
      end else if (!iow_q) begin
        armed_q <= 1'b0;
        if (armed_q) port_q <= hold_q;
      end
    end
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import iodec_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          SEL_W    = 3,
  parameter int          DEV_W    = 5,
  parameter int          NARROW_W = 8,
  parameter int          LIN_W    = 2,
  parameter int unsigned BASE_HI  = 0,
  parameter bit          LINEAR   = 1'b0,
  parameter int          IN_SLOT  = 3,
  parameter int          IN_OFS   = 4,
  parameter int          OUT_SLOT = 4,
  parameter int          OUT_OFS  = 1,
  localparam int         NSEL     = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aen,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_wide,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic [NSEL-1:0]   sel_n,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out
);
  localparam int        LOW_W = SEL_W + DEV_W;
  localparam dec_mode_e MODE  = LINEAR ? DEC_LINEAR : DEC_ABSOLUTE;

  logic             blk_en;
  logic [SEL_W-1:0] slot;
  logic [DEV_W-1:0] dev;
  logic             in_hit;
  logic             out_hit;
  logic             wr_commit;
  logic [DATA_W-1:0] wr_hold;

  assign slot = addr[LOW_W-1:DEV_W];
  assign dev  = addr[DEV_W-1:0];

  io_blk_enable #(
    .ADDR_W  (ADDR_W),
    .LOW_W   (LOW_W),
    .NARROW_W(NARROW_W),
    .LIN_W   (LIN_W),
    .BASE_HI (BASE_HI),
    .MODE    (MODE)
  ) u_en (
    .aen      (aen),
    .addr_wide(addr_wide),
    .addr     (addr),
    .blk_en   (blk_en)
  );

  io_sel_dec #(.SEL_W(SEL_W)) u_sel (
    .blk_en(blk_en),
    .slot  (slot),
    .sel_n (sel_n)
  );

  assign in_hit  = !sel_n[IN_SLOT]  && offset_ok(8'(dev), 8'(IN_OFS),  MODE);
  assign out_hit = !sel_n[OUT_SLOT] && offset_ok(8'(dev), 8'(OUT_OFS), MODE);

  // read port: drive only while selected and read-strobed
  assign rd_oe   = in_hit && !ior_n;
  assign rd_data = rd_oe ? port_in : '0;

  io_out_port #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (out_hit),
    .iow_n  (iow_n),
    .wr_data(wr_data),
    .port_q (port_out),
    .hold_q (wr_hold),
    .commit (wr_commit)
  );
endmodule

// File: rtl/io_dec_checker.sv
module io_dec_checker #(
  parameter int NSEL    = 8,
  parameter int DATA_W  = 8,
  parameter int IN_SLOT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aen,
  input logic              ior_n,
  input logic [NSEL-1:0]   sel_n,
  input logic              rd_oe,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] port_out,
  input logic [DATA_W-1:0] wr_hold,
  input logic              wr_commit
);
  assert_aen_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (sel_n == '1) && !rd_oe);

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));

  assert_oe_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !ior_n && !sel_n[IN_SLOT]);

  assert_bus_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));

  assert_commit_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (port_out == $past(wr_hold)));

  assert_port_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(port_out));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (port_out == '0));
endmodule

bind io_port_decoder io_dec_checker #(
  .NSEL   (NSEL),
  .DATA_W (DATA_W),
  .IN_SLOT(IN_SLOT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .aen      (aen),
  .ior_n    (ior_n),
  .sel_n    (sel_n),
  .rd_oe    (rd_oe),
  .rd_data  (rd_data),
  .port_out (port_out),
  .wr_hold  (wr_hold),
  .wr_commit(wr_commit)
);

// File: tb/tb_io_port_decoder.sv
module tb_io_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aen = 1'b1;
  logic [15:0] addr = '0;
  logic        addr_wide = 1'b1;
  logic        ior_n = 1'b1;
  logic        iow_n = 1'b1;
  logic [7:0]  wr_data = '0;
  logic [7:0]  port_in = '0;
  logic [7:0]  rdd [2];
  logic        oe  [2];
  logic [7:0]  seln [2];
  logic [7:0]  pout [2];

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  io_port_decoder #(.BASE_HI(0), .LINEAR(1'b0), .IN_SLOT(3), .IN_OFS(4),
                    .OUT_SLOT(4), .OUT_OFS(1)) dut (
    .clk(clk), .rst_n(rst_n), .aen(aen), .addr(addr), .addr_wide(addr_wide),
    .ior_n(ior_n), .iow_n(iow_n), .wr_data(wr_data), .rd_data(rdd[0]),
    .rd_oe(oe[0]), .sel_n(seln[0]), .port_in(port_in), .port_out(pout[0]));

  io_port_decoder #(.BASE_HI(0), .LINEAR(1'b1), .IN_SLOT(3), .IN_OFS(4),
                    .OUT_SLOT(4), .OUT_OFS(1)) dut_lin (
    .clk(clk), .rst_n(rst_n), .aen(aen), .addr(addr), .addr_wide(addr_wide),
    .ior_n(ior_n), .iow_n(iow_n), .wr_data(wr_data), .rd_data(rdd[1]),
    .rd_oe(oe[1]), .sel_n(seln[1]), .port_in(port_in), .port_out(pout[1]));

  typedef struct {
    string      tag;
    logic [7:0] sel [2];
    logic       oe  [2];
    logic [7:0] rdd [2];
    logic [7:0] out [2];
  } exp_t;

  exp_t sb[$];

  // bench model state
  logic [7:0] m_out [2] = '{8'h00, 8'h00};
  logic [7:0] m_hold [2] = '{8'h00, 8'h00};
  bit         m_arm [2] = '{0, 0};
  bit         m_prev_wn = 1;

  function automatic logic [7:0] model_sel(logic [15:0] a, bit wide, bit en_hi, bit lin);
    logic [7:0] upper;
    bit ok;
    upper = wide ? a[15:8] : 8'h00;
    ok = lin ? (upper % 4 == 0) : (upper == 0);
    if (en_hi || !ok) return 8'hFF;
    return ~(8'h01 << (a >> 5) % 8);
  endfunction

  function automatic bit model_port(logic [7:0] s, logic [15:0] a, int slot, int ofs, bit lin);
    return (s[slot] == 1'b0) && (lin || (a % 32 == ofs));
  endfunction

  task automatic step(string tag, bit r, bit a_hi, logic [15:0] ad, bit w,
                      bit rn, bit wn, logic [7:0] wd, logic [7:0] pin);
    exp_t e;
    @(posedge clk); #1;
    rst_n = r; aen = a_hi; addr = ad; addr_wide = w;
    ior_n = rn; iow_n = wn; wr_data = wd; port_in = pin;
    e.tag = tag;
    for (int k = 0; k < 2; k++) begin
      bit hit_in, hit_out;
      if (!r) begin m_out[k] = 0; m_hold[k] = 0; m_arm[k] = 0; end
      e.sel[k] = model_sel(ad, w, a_hi, k == 1);
      hit_in  = model_port(e.sel[k], ad, 3, 4, k == 1);
      hit_out = model_port(e.sel[k], ad, 4, 1, k == 1);
      e.oe[k]  = hit_in && !rn;
      e.rdd[k] = e.oe[k] ? pin : 8'h00;
      e.out[k] = m_out[k];
      if (r) begin
        if (!wn) begin
          m_arm[k] = hit_out;
          if (hit_out) m_hold[k] = wd;
        end else if (!m_prev_wn) begin
          if (m_arm[k]) m_out[k] = m_hold[k];
          m_arm[k] = 0;
        end
      end
    end
    m_prev_wn = r ? wn : 1'b1;
    sb.push_back(e);
  endtask

  task automatic cmp(string tag, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // monitor: compares one scoreboard item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      for (int k = 0; k < 2; k++) begin
        string nm;
        nm = (k == 0) ? "abs" : "lin";
        cmp(e.tag, {nm, " sel_n"},    seln[k], e.sel[k]);
        cmp(e.tag, {nm, " rd_oe"},    8'(oe[k]), 8'(e.oe[k]));
        cmp(e.tag, {nm, " rd_data"},  rdd[k],  e.rdd[k]);
        cmp(e.tag, {nm, " port_out"}, pout[k], e.out[k]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    step("R10 reset", 0, 1, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    step("R10 reset", 0, 0, 16'h0081, 1, 1, 1, 8'hAA, 8'h00);
    // R1 bus owned by another master
    step("R1 aen high read", 1, 1, 16'h0064, 1, 0, 1, 8'h00, 8'h5C);
    step("R1 aen high write", 1, 1, 16'h0081, 1, 1, 0, 8'h99, 8'h00);
    step("R1 aen high release", 1, 1, 16'h0081, 1, 1, 1, 8'h99, 8'h00);
    step("R9 aen write ignored", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R2 sweep of all slots, strobes in several states
    for (int i = 0; i < 8; i++)
      step("R2 slot sweep", 1, 0, 16'(i * 32 + 7), 1, i % 2, 1, 8'h00, 8'h33);
    // R3 and R5: high lines
    step("R3 bit9 set", 1, 0, 16'h0264, 1, 0, 1, 8'h00, 8'h12);
    step("R3 R5 bit12 alias", 1, 0, 16'h1064, 1, 0, 1, 8'h00, 8'h34);
    step("R3 R5 top bits alias", 1, 0, 16'hF0E0, 1, 1, 1, 8'h00, 8'h00);
    // R4 short access ignores upper byte
    step("R4 narrow read", 1, 0, 16'hFF64, 0, 0, 1, 8'h00, 8'hC3);
    step("R4 narrow slot7", 1, 0, 16'h03E2, 0, 1, 1, 8'h00, 8'h00);
    // R6 and R7 read port
    step("R6 read hit", 1, 0, 16'h0064, 1, 0, 1, 8'h00, 8'hA5);
    step("R6 no strobe", 1, 0, 16'h0064, 1, 1, 1, 8'h00, 8'hA5);
    step("R7 R5 wrong offset", 1, 0, 16'h0065, 1, 0, 1, 8'h00, 8'h5A);
    step("R5 offset alias", 1, 0, 16'h007F, 1, 0, 1, 8'h00, 8'h0F);
    // R8 write to the output port
    step("R8 write low", 1, 0, 16'h0081, 1, 1, 0, 8'h3C, 8'h00);
    step("R8 write release", 1, 0, 16'h0081, 1, 1, 1, 8'h3C, 8'h00);
    step("R8 value visible", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R9 and R5 write at offset alias
    step("R9 R5 other offset", 1, 0, 16'h0082, 1, 1, 0, 8'h77, 8'h00);
    step("R9 R5 release", 1, 0, 16'h0082, 1, 1, 1, 8'h77, 8'h00);
    step("R9 R5 after", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R9 aen high during a write at the port address
    step("R9 aen write", 1, 1, 16'h0081, 1, 1, 0, 8'h11, 8'h00);
    step("R9 aen release", 1, 1, 16'h0081, 1, 1, 1, 8'h11, 8'h00);
    step("R9 aen after", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R11 read strobe at the output port, write strobe at the read port
    step("R11 read at out port", 1, 0, 16'h0081, 1, 0, 1, 8'h22, 8'h66);
    step("R11 read after", 1, 0, 16'h0081, 1, 1, 1, 8'h22, 8'h66);
    step("R11 write at in port", 1, 0, 16'h0064, 1, 1, 0, 8'h44, 8'h66);
    step("R11 write release", 1, 0, 16'h0064, 1, 1, 1, 8'h44, 8'h66);
    step("R11 after", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R5 linear alias on a high line, R8 long strobe with last data winning
    step("R5 high alias write", 1, 0, 16'h1081, 1, 1, 0, 8'h5A, 8'h00);
    step("R5 high alias release", 1, 0, 16'h1081, 1, 1, 1, 8'h5A, 8'h00);
    step("R8 long strobe a", 1, 0, 16'h0081, 1, 1, 0, 8'h81, 8'h00);
    step("R8 long strobe b", 1, 0, 16'h0081, 1, 1, 0, 8'hE7, 8'h00);
    step("R8 long release", 1, 0, 16'h0081, 1, 1, 1, 8'hE7, 8'h00);
    step("R8 long after", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    // R10 reset in the middle of operation
    step("R10 mid reset", 0, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    step("R10 after reset", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    step("R10 idle", 1, 0, 16'h0000, 1, 1, 1, 8'h00, 8'h00);
    @(posedge clk);
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule